// File: doc/BRIEF.md
# Calendar Prescaler with Initialization Handshake

The block turns a slow kernel clock into a one-cycle calendar tick at 1 Hz. It uses two down-counters in series. The first stage (asynchronous divider) counts every kernel cycle and sends one enable pulse each time it wraps. The second stage (synchronous divider) counts those pulses, and the tick fires when it wraps. The tick period in kernel cycles is (A+1)×(S+1), where A is the asynchronous divider value and S is the synchronous divider value. The reset values A=127 and S=255 give 1 Hz from a 32768 Hz clock.

Before software changes the divider values or the calendar, it runs an initialization handshake. It sets a request bit. The block waits a short delay, then freezes both counters at their reload values and raises a ready flag. Clearing the request releases the counters. After a further delay, a resync flag reports that the calendar shadows are valid again. Software can also clear the resync flag at any time; the block sets it again after the same delay.

The handshake is a four-state machine:
- **HS_RUN** goes to HS_ENTER when the request is set. It goes to HS_RESYNC when software clears the resync flag.
- **HS_ENTER** counts HS_DLY cycles, then goes to HS_FROZEN. It falls back to HS_RUN if the request drops first (abort).
- **HS_FROZEN** holds the counters and goes to HS_RESYNC when the request drops.
- **HS_RESYNC** counts HS_DLY cycles, then goes to HS_RUN and sets the resync flag. It goes to HS_ENTER on a request. A new clear restarts its count.

Counting runs in HS_RUN, HS_ENTER and HS_RESYNC.

Top module: `cal_prescaler`

## Requirements
- R1: After reset, `presc_o` reads 0x007F00FF, `status_o` reads 0 and `tick` is low.
- R2: While counting, `tick` is high for exactly one cycle every (A+1)×(S+1) cycles. The first tick after reset follows the (A+1)×(S+1)-th clock edge. With A=S=0, `tick` is high on every cycle.
- R3: The `status_o` layout is:
  - bit 7: request readback
  - bit 6: ready
  - bit 5: resync
  - bit 4: initialized
  - bits 3:0: always zero
- R4: A status write (`wr_sel`=0) takes bit 7 of the data as the request. Ready rises on the HS_DLY+1-th edge after the edge that captured the request (edge 3 with the default HS_DLY=2).
- R5: While ready is high, no tick occurs. When the request is cleared, ready falls on the next edge. The first tick follows edge 1+(A+1)×(S+1) counted from the clearing edge.
- R6: A status write with bit 5 = 0 clears resync at its own edge. Outside initialization, resync rises again HS_DLY edges later.
- R7: Resync clears when ready rises. It rises HS_DLY+1 edges after the edge that cleared the request.
- R8: A prescaler write (`wr_sel`=1) loads S from bits 14:0 and A from bits 22:16, but only while ready is high. At any other time it is ignored. `presc_o` reads back S at bits 14:0 and A at bits 22:16; all other bits are zero.
- R9: The initialized flag rises one edge after `cal_year` is nonzero. It stays set until reset.
- R10: If the request is cleared before ready rises, ready never rises and counting continues without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = status, 1 = prescaler |
| wr_data | input | 32 | Write data |
| cal_year | input | 8 | Calendar year field, used for the initialized flag |
| tick | output | 1 | One-cycle calendar tick |
| status_o | output | 8 | Status flags |
| presc_o | output | 32 | Divider readback |

## Verification
The hardest case to reach is an abort: the request cleared while the machine is still in HS_ENTER. The bench reaches it by issuing two status writes on consecutive cycles, so that the clear arrives one edge after the request. A second hard case is the degenerate divider A=S=0. It can only be loaded through a complete handshake, and the bench performs that handshake and then observes a tick on every cycle. The behavioural model tracks the tick phase as a single count modulo the period, so any slip between the two stages is reported on the first cycle where it shows.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
    typedef enum logic [1:0] {
        HS_RUN,
        HS_ENTER,
        HS_FROZEN,
        HS_RESYNC
    } hs_state_t;

    localparam int REQ_BIT   = 7;
    localparam int RDY_BIT   = 6;
    localparam int RSF_BIT   = 5;
    localparam int INITS_BIT = 4;
    localparam int SYNC_LSB  = 0;
    localparam int ASYNC_LSB = 16;
endpackage

// File: rtl/pscl_stage.sv
module pscl_stage #(
    parameter int W       = 7,
    parameter int RST_VAL = 127
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         step,
    input  logic [W-1:0] reload,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (hold) begin
            cnt_q <= reload;
        end else if (step) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end

    assign wrap = step && !hold && (cnt_q == '0);
endmodule

// File: rtl/pscl_handshake.sv
module pscl_handshake
    import pscl_pkg::*;
#(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic rsf_clr,
    output logic frozen,
    output logic rsf
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;

    hs_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          dly_done;

    assign dly_done = (cnt_q == CW'(DLY - 1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HS_RUN: begin
                if (req) begin
                    state_d = HS_ENTER;
                    cnt_d   = '0;
                end else if (rsf_clr) begin
                    state_d = HS_RESYNC;
                    cnt_d   = '0;
                end
            end
            HS_ENTER: begin
                if (!req) begin
                    state_d = HS_RUN;
                end else if (dly_done) begin
                    state_d = HS_FROZEN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            HS_FROZEN: begin
                if (!req) begin
                    state_d = HS_RESYNC;
                    cnt_d   = '0;
                end
            end
            HS_RESYNC: begin
                if (req) begin
                    state_d = HS_ENTER;
                    cnt_d   = '0;
                end else if (rsf_clr) begin
                    cnt_d = '0;
                end else if (dly_done) begin
                    state_d = HS_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = HS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsf <= 1'b0;
        end else if (rsf_clr) begin
            rsf <= 1'b0;
        end else if (state_q == HS_ENTER && state_d == HS_FROZEN) begin
            rsf <= 1'b0;
        end else if (state_q == HS_RESYNC && state_d == HS_RUN) begin
            rsf <= 1'b1;
        end
    end

    assign frozen = (state_q == HS_FROZEN);
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
    import pscl_pkg::*;
#(
    parameter int ASYNC_W   = 7,
    parameter int SYNC_W    = 15,
    parameter int ASYNC_RST = 127,
    parameter int SYNC_RST  = 255,
    parameter int HS_DLY    = 2,
    parameter int YEAR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [YEAR_W-1:0] cal_year,
    output logic              tick,
    output logic [7:0]        status_o,
    output logic [31:0]       presc_o
);
    logic [ASYNC_W-1:0] async_div_q;
    logic [SYNC_W-1:0]  sync_div_q;
    logic req_q, inits_q, tick_q;
    logic frozen, rsf, rsf_clr, stat_wr, presc_wr;
    logic async_wrap, sync_wrap;

    assign stat_wr  = wr_en && !wr_sel;
    assign presc_wr = wr_en && wr_sel && frozen;
    assign rsf_clr  = stat_wr && !wr_data[RSF_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q       <= 1'b0;
            inits_q     <= 1'b0;
            tick_q      <= 1'b0;
            async_div_q <= ASYNC_W'(ASYNC_RST);
            sync_div_q  <= SYNC_W'(SYNC_RST);
        end else begin
            tick_q <= sync_wrap;
            if (stat_wr) req_q <= wr_data[REQ_BIT];
            if (cal_year != '0) inits_q <= 1'b1;
            if (presc_wr) begin
                async_div_q <= wr_data[ASYNC_LSB +: ASYNC_W];
                sync_div_q  <= wr_data[SYNC_LSB +: SYNC_W];
            end
        end
    end

    pscl_handshake #(.DLY(HS_DLY)) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_q),
        .rsf_clr (rsf_clr),
        .frozen  (frozen),
        .rsf     (rsf)
    );

    pscl_stage #(.W(ASYNC_W), .RST_VAL(ASYNC_RST)) u_async (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (frozen),
        .step   (1'b1),
        .reload (async_div_q),
        .wrap   (async_wrap)
    );

    pscl_stage #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (frozen),
        .step   (async_wrap),
        .reload (sync_div_q),
        .wrap   (sync_wrap)
    );

    assign tick = tick_q;

    always_comb begin
        status_o            = '0;
        status_o[REQ_BIT]   = req_q;
        status_o[RDY_BIT]   = frozen;
        status_o[RSF_BIT]   = rsf;
        status_o[INITS_BIT] = inits_q;
        presc_o                        = '0;
        presc_o[SYNC_LSB +: SYNC_W]    = sync_div_q;
        presc_o[ASYNC_LSB +: ASYNC_W]  = async_div_q;
    end
endmodule

// File: rtl/pscl_chk.sv
module pscl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic [7:0]  status,
    input logic [31:0] presc
);
    // R5
    frozen_notick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && $past(status[6])) |-> !tick);

    // R4
    rdy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> $past(status[7]));

    // R5
    rdy_drop_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[6]) |-> !$past(status[7]));

    // R8
    presc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(status[6]) |-> $stable(presc));

    // R7
    rsf_not_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[5]) |-> !status[6]);

    // R9
    inits_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status[4]) |-> status[4]);
endmodule

bind cal_prescaler pscl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .status (status_o),
    .presc  (presc_o)
);

// File: tb/sim_cal_prescaler.sv
module sim_cal_prescaler;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  cal_year = '0;
    logic        tick;
    logic [7:0]  status_o;
    logic [31:0] presc_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_prescaler u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cal_year(cal_year), .tick(tick),
        .status_o(status_o), .presc_o(presc_o)
    );

    // behavioural reference model
    int m_a, m_s, m_ph, m_stg, m_cnt;
    bit m_req, m_rsf, m_inits, m_tick;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 127; m_s = 255; m_ph = 0; m_stg = 0; m_cnt = 0;
            m_req = 0; m_rsf = 0; m_inits = 0; m_tick = 0;
        end else begin
            int stg_old, per;
            bit req_old, clr;
            stg_old = m_stg;
            req_old = m_req;
            clr = wr_en && !wr_sel && !wr_data[5];
            per = (m_a + 1) * (m_s + 1);
            if (stg_old == 2) begin
                m_ph = 0; m_tick = 0;
            end else begin
                m_tick = (m_ph == per - 1);
                m_ph = (m_ph + 1) % per;
            end
            if (wr_en && wr_sel && stg_old == 2) begin
                m_a = int'(wr_data[22:16]);
                m_s = int'(wr_data[14:0]);
            end
            if (wr_en && !wr_sel) m_req = wr_data[7];
            if (clr) m_rsf = 0;
            if (cal_year != 0) m_inits = 1;
            case (stg_old)
                0: if (req_old) begin m_stg = 1; m_cnt = 0; end
                   else if (clr) begin m_stg = 3; m_cnt = 0; end
                1: if (!req_old) m_stg = 0;
                   else if (m_cnt == 1) begin m_stg = 2; m_rsf = 0; end
                   else m_cnt++;
                2: if (!req_old) begin m_stg = 3; m_cnt = 0; end
                default: if (req_old) begin m_stg = 1; m_cnt = 0; end
                   else if (clr) m_cnt = 0;
                   else if (m_cnt == 1) begin m_stg = 0; m_rsf = 1; end
                   else m_cnt++;
            endcase
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 tick model", {31'b0, tick}, {31'b0, m_tick});
            chk("R3 status model", {24'b0, status_o},
                {24'b0, m_req, (m_stg == 2), m_rsf, m_inits, 4'b0});
            chk("R8 presc model", presc_o,
                {9'b0, 7'(m_a), 1'b0, 15'(m_s)});
        end
    end

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        int first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 presc", presc_o, 32'h007F00FF);
        chk("R1 status", {24'b0, status_o}, 32'h0);
        chk("R1 tick", {31'b0, tick}, 0);
        // R2 first tick at reset period
        first = 1;
        while (!tick && first < 40000) begin @(negedge clk); first++; end
        chk("R2 first tick index", first, 32768);
        // R4 enter init
        wr(0, 32'hA0);
        repeat (2) @(negedge clk);
        chk("R4 rdy low before delay", {31'b0, status_o[6]}, 0);
        @(negedge clk);
        chk("R4 rdy high", {31'b0, status_o[6]}, 1);
        chk("R7 rsf cleared in init", {31'b0, status_o[5]}, 0);
        // R8 program A=2 S=3 -> period 12
        wr(1, 32'h0002_0003);
        chk("R8 presc loaded", presc_o, 32'h0002_0003);
        repeat (20) @(negedge clk);
        chk("R5 no tick frozen", {31'b0, tick}, 0);
        // R5/R7 leave init
        wr(0, 32'h20);
        chk("R5 rdy still high", {31'b0, status_o[6]}, 1);
        @(negedge clk);
        chk("R5 rdy falls", {31'b0, status_o[6]}, 0);
        @(negedge clk);
        chk("R7 rsf not yet", {31'b0, status_o[5]}, 0);
        @(negedge clk);
        chk("R7 rsf set", {31'b0, status_o[5]}, 1);
        repeat (9) @(negedge clk);
        chk("R5 no early tick", {31'b0, tick}, 0);
        @(negedge clk);
        chk("R5 first tick after exit", {31'b0, tick}, 1);
        // R8 ignored write outside init
        wr(1, 32'h0005_0005);
        chk("R8 ignored", presc_o, 32'h0002_0003);
        repeat (30) @(negedge clk);
        // R6 software resync clear
        wr(0, 32'h00);
        chk("R6 rsf cleared", {31'b0, status_o[5]}, 0);
        @(negedge clk);
        chk("R6 rsf pending", {31'b0, status_o[5]}, 0);
        @(negedge clk);
        chk("R6 rsf back", {31'b0, status_o[5]}, 1);
        // R10 abort during enter
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'hA0;
        @(negedge clk);
        wr_data = 32'h20;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk("R10 no rdy after abort", {31'b0, status_o[6]}, 0);
            @(negedge clk);
        end
        repeat (25) @(negedge clk);
        // R9 initialized flag
        chk("R9 inits low", {31'b0, status_o[4]}, 0);
        cal_year = 8'h25;
        @(negedge clk);
        cal_year = 8'h00;
        chk("R9 inits set", {31'b0, status_o[4]}, 1);
        repeat (3) @(negedge clk);
        chk("R9 inits sticky", {31'b0, status_o[4]}, 1);
        // R2 degenerate divider A=S=0
        wr(0, 32'hA0);
        repeat (3) @(negedge clk);
        wr(1, 32'h0);
        wr(0, 32'h20);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            chk("R2 tick every cycle", {31'b0, tick}, 1);
            @(negedge clk);
        end
        finish_run();
    end
endmodule